// File: doc/BRIEF.md
# Multiple-Polynomial Reseeding Scan Pattern Generator

This block is a built-in test pattern source that drives one scan chain from a single shift register with linear feedback. Its feedback taps are picked from a fixed set of sixteen polynomials. After a start pulse the register first runs freely for a programmable number of scan loads. These pseudorandom loads catch the faults that are easy to detect. The block then switches to a deterministic phase. It fetches seed words one at a time from an external synchronous seed memory, loads each seed into all stages in one cycle, and expands it into one scan load.

The seeds sit in memory grouped by the polynomial they need. So a seed word does not carry a full polynomial number. It carries one extra flag bit above the seed, and that bit moves the block to the next polynomial before the seed is expanded. When the last seed has been shifted out, the block raises done and stays idle until it is started again.

Top module: `mp_reseed_tpg`

## Requirements
- R1: After reset, done, scan_en, seed_rd and poly_err are all low.
- R2: A start in the idle or finished state reloads the register with RESET_SEED (default 1) and selects polynomial 0. It then emits pr_patterns × SCAN_LEN bits with scan_en high. In every shift cycle scan_out is stage S-1. The register moves to {state[S-2:0], fb}, where fb is the XOR of the stages set in the current tap mask.
- R3: The tap mask of polynomial k has bit S-1 set, bit 0 set, and bits 4:1 equal to k. All other bits are clear.
- R4: In the deterministic phase, seed i (i = 0 … seed_total-1, in order) is requested with seed_rd high and seed_addr = i. The data is taken one cycle later from seed_data[S-1:0] and loaded into all stages at once. It is then expanded into SCAN_LEN bits by the rule of R2.
- R5: When seed_data[S] (the advance flag) is 1, the polynomial number rises by one before that seed is expanded. The rise lasts for all later seeds.
- R6: The polynomial number stops at 15. A flag that arrives while it is already 15 sets poly_err, and poly_err stays set until the next start.
- R7: scan_en is low in the request cycle and in the load cycle. So every deterministic scan load is preceded by exactly two cycles with scan_en low, and seed_rd is never high together with scan_en.
- R8: After the last bit of the last seed, done goes high and stays high, with scan_en and seed_rd low, until the next start.
- R9: With pr_patterns = 0 the pseudorandom phase is skipped. With seed_total = 0 the block finishes right after the pseudorandom phase.
- R10: A new start clears poly_err and rebuilds the whole stream from RESET_SEED and polynomial 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run when idle or finished |
| pr_patterns | input | CW | Number of pseudorandom scan loads |
| seed_total | input | CW | Number of seeds to fetch |
| seed_rd | output | 1 | Seed read request |
| seed_addr | output | CW | Seed word address |
| seed_data | input | S+1 | Seed word: bit S is the advance flag, bits S-1:0 the seed |
| scan_out | output | 1 | Serial scan data |
| scan_en | output | 1 | High while scan data is shifting |
| done | output | 1 | Run finished |
| poly_err | output | 1 | Sticky: advance flag seen at polynomial 15 |

## Verification
The bench rebuilds every scan bit from a model of the register. A design that ignored the advance flag, or that applied it one seed late, shows up in the tail bits of each load, after the new feedback has reached the output stage. It drives sixteen and more consecutive flags to hit saturation at polynomial 15. A design that wraps to 0 produces a wrong stream, and one without the sticky flag leaves poly_err low. It also runs with zero pseudorandom loads, with zero seeds, and with a restart after an error. These catch a counter compared off by one, an extra or missing load, and a restart that keeps the old polynomial or the old error bit.

// File: rtl/mp_reseed_tpg.sv
module mp_reseed_tpg #(
  parameter int S = 16,
  parameter int SCAN_LEN = 24,
  parameter int CW = 16,
  parameter logic [S-1:0] RESET_SEED = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] pr_patterns,
  input  logic [CW-1:0] seed_total,
  output logic          seed_rd,
  output logic [CW-1:0] seed_addr,
  input  logic [S:0]    seed_data,
  output logic          scan_out,
  output logic          scan_en,
  output logic          done,
  output logic          poly_err
);
  localparam int BW = $clog2(SCAN_LEN + 1);
  localparam logic [3:0] TOP_POLY = 4'd15;

  typedef enum logic [2:0] {IDLE, PR_SHIFT, REQ, LOAD, DET_SHIFT, FIN} st_t;

  function automatic logic [S-1:0] tap_mask(input logic [3:0] k);
    logic [S-1:0] m;
    m = '0;
    m[S-1] = 1'b1;
    m[4:1] = k;
    m[0] = 1'b1;
    return m;
  endfunction

  st_t st;
  logic [S-1:0] lfsr;
  logic [3:0] poly_idx;
  logic [BW-1:0] bit_cnt;
  logic [CW-1:0] pat_cnt, seed_idx;

  wire last_bit = bit_cnt == BW'(SCAN_LEN - 1);
  wire fb = ^(lfsr & tap_mask(poly_idx));
  wire [S-1:0] shifted = {lfsr[S-2:0], fb};
  wire idle_like = (st == IDLE) || (st == FIN);

  assign scan_out  = lfsr[S-1];
  assign scan_en   = (st == PR_SHIFT) || (st == DET_SHIFT);
  assign seed_rd   = st == REQ;
  assign seed_addr = seed_idx;
  assign done      = st == FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      lfsr     <= RESET_SEED;
      poly_idx <= '0;
      bit_cnt  <= '0;
      pat_cnt  <= '0;
      seed_idx <= '0;
      poly_err <= 1'b0;
    end else if (start && idle_like) begin
      lfsr     <= RESET_SEED;
      poly_idx <= '0;
      poly_err <= 1'b0;
      bit_cnt  <= '0;
      pat_cnt  <= '0;
      seed_idx <= '0;
      if (pr_patterns != '0)     st <= PR_SHIFT;
      else if (seed_total != '0) st <= REQ;
      else                       st <= FIN;
    end else begin
      case (st)
        PR_SHIFT: begin
          lfsr    <= shifted;
          bit_cnt <= last_bit ? '0 : bit_cnt + BW'(1);
          if (last_bit) begin
            pat_cnt <= pat_cnt + CW'(1);
            if (pat_cnt + CW'(1) == pr_patterns)
              st <= (seed_total != '0) ? REQ : FIN;
          end
        end
        REQ: st <= LOAD;
        LOAD: begin
          lfsr <= seed_data[S-1:0];
          if (seed_data[S]) begin
            if (poly_idx == TOP_POLY) poly_err <= 1'b1;
            else                      poly_idx <= poly_idx + 4'd1;
          end
          st <= DET_SHIFT;
        end
        DET_SHIFT: begin
          lfsr    <= shifted;
          bit_cnt <= last_bit ? '0 : bit_cnt + BW'(1);
          if (last_bit) begin
            seed_idx <= seed_idx + CW'(1);
            st <= (seed_idx + CW'(1) == seed_total) ? FIN : REQ;
          end
        end
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/mp_reseed_tpg_chk.sv
module mp_reseed_tpg_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          scan_en,
  input logic          seed_rd,
  input logic [CW-1:0] seed_addr,
  input logic [CW-1:0] seed_total,
  input logic          poly_err,
  input logic [3:0]    poly_idx
);
  // R7
  rd_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && seed_rd));
  // R7
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_rd |=> (!scan_en && !seed_rd));
  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_rd |-> (seed_addr < seed_total));
  // R6
  poly_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_idx == 4'd15 && !start) |=> (poly_idx == 4'd15));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_err && !start) |=> poly_err);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && !seed_rd));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind mp_reseed_tpg mp_reseed_tpg_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .scan_en(scan_en),
  .seed_rd(seed_rd), .seed_addr(seed_addr), .seed_total(seed_total),
  .poly_err(poly_err), .poly_idx(poly_idx)
);

// File: tb/mp_reseed_tpg_test.sv
`timescale 1ns/1ps
module mp_reseed_tpg_test;
  localparam int S = 16;
  localparam int L = 24;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] pr_patterns = 0, seed_total = 0;
  logic seed_rd, scan_out, scan_en, done, poly_err;
  logic [CW-1:0] seed_addr;
  logic [S:0] seed_data = '0;
  logic [S:0] mem [0:31];

  int tests = 0, fails = 0, cycles = 0;

  mp_reseed_tpg #(.S(S), .SCAN_LEN(L), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pr_patterns(pr_patterns),
    .seed_total(seed_total), .seed_rd(seed_rd), .seed_addr(seed_addr),
    .seed_data(seed_data), .scan_out(scan_out), .scan_en(scan_en),
    .done(done), .poly_err(poly_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (seed_rd) seed_data <= mem[seed_addr[4:0]];

  // model state
  logic mon_on = 0;
  logic [S-1:0] m_lfsr;
  logic [3:0] m_poly;
  logic m_err;
  int m_bits, m_pr, bad_bits, rd_n, bad_addr, gap, bad_gap;

  function automatic logic [S-1:0] mstep(logic [S-1:0] v, logic [3:0] k);
    logic [S-1:0] m;
    m = '0; m[S-1] = 1'b1; m[4:1] = k; m[0] = 1'b1;
    return {v[S-2:0], ^(v & m)};
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (mon_on && !done) begin
      if (seed_rd) begin
        if (seed_addr != CW'(rd_n)) bad_addr++;
        rd_n++;
      end
      if (scan_en) begin
        if (m_bits >= m_pr * L && (m_bits - m_pr * L) % L == 0) begin
          if (gap != 2) bad_gap++;
          m_lfsr = mem[(m_bits - m_pr * L) / L][S-1:0];
          if (mem[(m_bits - m_pr * L) / L][S]) begin
            if (m_poly == 4'd15) m_err = 1'b1;
            else m_poly = m_poly + 4'd1;
          end
        end
        if (scan_out !== m_lfsr[S-1]) bad_bits++;
        m_lfsr = mstep(m_lfsr, m_poly);
        m_bits++;
        gap = 0;
      end else gap++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int n, input int flag_mode);
    for (int i = 0; i < 32; i++) begin
      logic fl;
      fl = (flag_mode == 1) ? 1'b1 : (flag_mode == 2) ? 1'(i % 2) : 1'b0;
      mem[i] = {fl, S'(16'hACE1 ^ (i * 16'h3D5B) ^ (i << 9))};
    end
    if (n < 0) mem[0] = '0;
  endtask

  task automatic run(input string tag, input int pr, input int ns);
    int t;
    pr_patterns = CW'(pr); seed_total = CW'(ns);
    m_lfsr = S'(1); m_poly = 0; m_err = 0; m_bits = 0; m_pr = pr;
    bad_bits = 0; rd_n = 0; bad_addr = 0; gap = 0; bad_gap = 0;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0; mon_on = 1;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    mon_on = 0;
    @(negedge clk);
    check(bad_bits == 0, {tag, " stream R2 R3 R4 R5"}, bad_bits, 0);
    check(m_bits == (pr + ns) * L, {tag, " bit count R2 R4 R9"}, m_bits, (pr + ns) * L);
    check(rd_n == ns && bad_addr == 0, {tag, " seed reads R4"}, rd_n * 1000 + bad_addr, ns * 1000);
    check(bad_gap == 0, {tag, " load gap R7"}, bad_gap, 0);
    check(poly_err == m_err, {tag, " poly_err R6"}, poly_err, m_err);
    repeat (5) @(negedge clk);
    check(done && !scan_en && !seed_rd, {tag, " done hold R8"},
          {done, scan_en, seed_rd}, 3'b100);
  endtask

  initial begin
    fill(4, 0);
    repeat (3) @(negedge clk);
    check(!done && !scan_en && !seed_rd && !poly_err, "reset outputs R1",
          {done, scan_en, seed_rd, poly_err}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(negedge clk);
    check(!done && !scan_en && !seed_rd, "idle after reset R1",
          {done, scan_en, seed_rd}, 0);
    fill(0, 0);
    run("pseudo only R9", 3, 0);
    fill(4, 2);
    run("mixed flags", 2, 4);
    fill(3, 1);
    run("no pseudo R9", 0, 3);
    fill(18, 1);
    run("saturation R6", 1, 18);
    check(poly_err == 1'b1, "error raised R6", poly_err, 1);
    fill(5, 0);
    run("restart R10", 1, 5);
    check(poly_err == 1'b0, "error cleared R10", poly_err, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule